// File: doc/BRIEF.md
# Bus Hold Handshake Controller

This block decides who drives a local processor bus: the internal bus-cycle engine or an external master. The external master asks for the bus with a level-sensitive hold input. The block lets any bus cycle already running finish. It then turns off every pad driver (address/data, strobes, status, data-enable, direction, chip selects, DRAM row/column strobes) and raises the acknowledge. When the external master drops its request, the acknowledge falls and the pads are driven again.

An internal refresh request that arrives while the bus is held is latched. The controller then drops the acknowledge early, while the hold request is still high, to tell the external master that the bus is needed. The pads stay off until the external master actually lets go. The latched refresh then runs as the first cycle, ahead of any queued processor cycle.

The block also produces the data-transceiver controls. DT/R is high for a write and low for a read. DEN is active during processor cycles, is kept low for the first clock of any cycle that reverses the bus direction, and is never asserted for refresh cycles. The cycle sequencer, the refresh timer and the pads sit outside. They are seen here only as request/done strobes and one output-enable.

Top module: `bus_hold_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until the first bus cycle starts, hlda_o, bus_oe_o, den_o and dtr_o are all 0.
- R2: hold_i passes through a two-flop synchronizer. With the controller idle, bus_oe_o falls after the 3rd rising edge following a change of hold_i to 1, and hlda_o rises after the 4th.
- R3: A hold request seen during an active cycle does not release the bus until cyc_done_i is sampled high. The release then passes through the idle state.
- R4: hlda_o and bus_oe_o are never both 1, and bus_oe_o is 0 for at least one clock before hlda_o rises.
- R5: While the bus is released or being reclaimed, cyc_req_i is ignored and cyc_start_o stays 0.
- R6: When hold_i falls while the bus is held, hlda_o falls and bus_oe_o rises together, after the 3rd rising edge.
- R7: A refresh request (rfsh_req_i pulse) taken while the bus is held drops hlda_o one clock after it is latched, while hold_i is still high. bus_oe_o stays 0 until the synchronized hold is seen low.
- R8: A latched refresh is started (cyc_start_o=1 with cyc_rfsh_o=1) as the first cycle once the bus is reacquired, ahead of a pending cyc_req_i.
- R9: dtr_o takes cyc_wr_i (1 = write, 0 = read) when a processor cycle starts and keeps it between cycles. den_o is 1 only in an active processor cycle, never for a refresh cycle, and only while bus_oe_o is 1.
- R10: den_o is 0 in the first clock of any cycle whose direction differs from the previous one, so den_o is never 1 in a clock where dtr_o changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | External bus master request (asynchronous level) |
| cyc_req_i | input | 1 | Processor bus cycle pending |
| cyc_wr_i | input | 1 | Direction of the pending processor cycle, 1 = write |
| rfsh_req_i | input | 1 | Refresh request pulse from the refresh timer |
| cyc_done_i | input | 1 | Running bus cycle finishes this clock |
| cyc_start_o | output | 1 | Start a bus cycle (combinational grant) |
| cyc_rfsh_o | output | 1 | The cycle being started is a refresh |
| hlda_o | output | 1 | Bus hold acknowledge |
| bus_oe_o | output | 1 | Output enable for all bus, strobe and select pads |
| den_o | output | 1 | Data transceiver enable, active high |
| dtr_o | output | 1 | Transceiver direction, 1 = transmit |

## Verification
Hold changes take effect on a fixed schedule. After a change of hold_i, the output enable moves after the 3rd rising edge and the acknowledge after the 4th. A release by dropping hold_i acts on both after the 3rd edge. Starts, completions, refresh latching and the direction or DEN changes all show up after the first edge. The bench applies each vector at a falling edge and samples at the next falling edge, one rising edge later. Multi-edge latencies are spelled out as runs of consecutive vectors, so each expected value sits on the exact clock where the result is due.

// File: rtl/bhc_pkg.sv
package bhc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACTIVE,
    ST_REL,
    ST_HELD,
    ST_RECLAIM
  } bhc_state_e;
endpackage

// File: rtl/bhc_sync.sv
module bhc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/bhc_arb.sv
module bhc_arb
  import bhc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_s_i,
  input  logic cyc_req_i,
  input  logic rfsh_req_i,
  input  logic cyc_done_i,
  output logic start_o,
  output logic start_rfsh_o,
  output logic active_o,
  output logic hlda_o,
  output logic bus_oe_o
);
  bhc_state_e state_q, state_d;
  logic       drive_q;
  logic       pend_q;

  // refresh has priority over both hold and processor cycles
  assign start_rfsh_o = (state_q == ST_IDLE) && pend_q;
  assign start_o      = (state_q == ST_IDLE) && (pend_q || (!hold_s_i && cyc_req_i));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_o) state_d = ST_ACTIVE;
                  else if (hold_s_i) state_d = ST_REL;
      ST_ACTIVE:  if (cyc_done_i) state_d = ST_IDLE;
      ST_REL:     state_d = ST_HELD;
      ST_HELD:    if (!hold_s_i) state_d = ST_IDLE;
                  else if (pend_q) state_d = ST_RECLAIM;
      ST_RECLAIM: if (!hold_s_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      drive_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= (pend_q && !start_rfsh_o) || rfsh_req_i;
      if (start_o || ((state_q == ST_HELD || state_q == ST_RECLAIM) && state_d == ST_IDLE))
        drive_q <= 1'b1;
    end
  end

  assign active_o = (state_q == ST_ACTIVE);
  assign hlda_o   = (state_q == ST_HELD);
  assign bus_oe_o = drive_q && (state_q == ST_IDLE || state_q == ST_ACTIVE);
endmodule

// File: rtl/bhc_dir.sv
module bhc_dir (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic start_rfsh_i,
  input  logic cyc_wr_i,
  input  logic active_i,
  output logic den_o,
  output logic dtr_o
);
  logic dir_q, turn_q, rfsh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= 1'b0;
      turn_q <= 1'b0;
      rfsh_q <= 1'b0;
    end else if (start_i) begin
      rfsh_q <= start_rfsh_i;
      turn_q <= !start_rfsh_i && (cyc_wr_i != dir_q);
      if (!start_rfsh_i) dir_q <= cyc_wr_i;
    end else begin
      turn_q <= 1'b0;
    end
  end

  // one dead clock on DEN whenever the transceiver turns around
  assign den_o = active_i && !rfsh_q && !turn_q;
  assign dtr_o = dir_q;
endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic cyc_req_i,
  input  logic cyc_wr_i,
  input  logic rfsh_req_i,
  input  logic cyc_done_i,
  output logic cyc_start_o,
  output logic cyc_rfsh_o,
  output logic hlda_o,
  output logic bus_oe_o,
  output logic den_o,
  output logic dtr_o
);
  logic hold_s;
  logic active;

  bhc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (hold_i),
    .q_o   (hold_s)
  );

  bhc_arb u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_s_i    (hold_s),
    .cyc_req_i   (cyc_req_i),
    .rfsh_req_i  (rfsh_req_i),
    .cyc_done_i  (cyc_done_i),
    .start_o     (cyc_start_o),
    .start_rfsh_o(cyc_rfsh_o),
    .active_o    (active),
    .hlda_o      (hlda_o),
    .bus_oe_o    (bus_oe_o)
  );

  bhc_dir u_dir (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (cyc_start_o),
    .start_rfsh_i(cyc_rfsh_o),
    .cyc_wr_i    (cyc_wr_i),
    .active_i    (active),
    .den_o       (den_o),
    .dtr_o       (dtr_o)
  );
endmodule

// File: rtl/bhc_chk.sv
module bhc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic hold_s,
  input logic hlda_o,
  input logic bus_oe_o,
  input logic den_o,
  input logic dtr_o,
  input logic cyc_start_o
);
  // R4
  oe_hlda_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hlda_o && bus_oe_o));

  // R4
  hlda_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hlda_o) |-> !$past(bus_oe_o));

  // R5
  no_start_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> !cyc_start_o);

  // R6
  reacquire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(hlda_o) && bus_oe_o) |-> !hold_s);

  // R9
  den_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    den_o |-> bus_oe_o);

  // R10
  den_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dtr_o) |-> !den_o);
endmodule

bind bus_hold_ctrl bhc_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hold_s     (hold_s),
  .hlda_o     (hlda_o),
  .bus_oe_o   (bus_oe_o),
  .den_o      (den_o),
  .dtr_o      (dtr_o),
  .cyc_start_o(cyc_start_o)
);

// File: tb/sim_bus_hold_ctrl.sv
`timescale 1ns/1ps
module sim_bus_hold_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hold_i = 1'b0, cyc_req_i = 1'b0, cyc_wr_i = 1'b0, rfsh_req_i = 1'b0, cyc_done_i = 1'b0;
  logic cyc_start_o, cyc_rfsh_o, hlda_o, bus_oe_o, den_o, dtr_o;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  bus_hold_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .hold_i(hold_i), .cyc_req_i(cyc_req_i),
    .cyc_wr_i(cyc_wr_i), .rfsh_req_i(rfsh_req_i), .cyc_done_i(cyc_done_i),
    .cyc_start_o(cyc_start_o), .cyc_rfsh_o(cyc_rfsh_o), .hlda_o(hlda_o),
    .bus_oe_o(bus_oe_o), .den_o(den_o), .dtr_o(dtr_o)
  );

  // inputs {hold,req,wr,rfsh,done} | expected {hlda,oe,den,dtr,start,rfsh} after one edge
  localparam int NV = 28;
  localparam logic [10:0] VEC [NV] = '{
    11'b00000_000000, // 0  R1 idle after reset
    11'b01000_011000, // 1  R9 read, no turn
    11'b00001_010000, // 2
    11'b01100_010100, // 3  R10 turn to write
    11'b00100_011100, // 4
    11'b00101_010100, // 5  dtr held
    11'b01000_010000, // 6  turn to read
    11'b10000_011000, // 7  R3 hold during cycle
    11'b10000_011000, // 8
    11'b10001_010000, // 9  done -> idle
    11'b11000_000000, // 10 R4 oe off first
    11'b11000_100000, // 11 R2 hlda
    11'b11010_100000, // 12 R7 refresh latched
    11'b11000_000000, // 13 hlda dropped early
    11'b01000_000000, // 14 R5 req ignored
    11'b01000_000000, // 15
    11'b01000_010011, // 16 R8 refresh granted first
    11'b01000_010000, // 17 refresh: no DEN
    11'b01001_010010, // 18 cpu next
    11'b01000_011000, // 19
    11'b00001_010000, // 20
    11'b10000_010000, // 21 R2
    11'b10000_010000, // 22
    11'b10000_000000, // 23
    11'b10000_100000, // 24
    11'b00000_100000, // 25 R6
    11'b00000_100000, // 26
    11'b00000_010000  // 27
  };

  function automatic string vtag(int i);
    if (i == 0) return "R1";
    if (i <= 2 || i == 5 || i == 17) return "R9";
    if (i <= 6) return "R10";
    if (i <= 9) return "R3";
    if (i == 10 || i == 23) return "R4";
    if (i <= 11 || (i >= 20 && i <= 24)) return "R2";
    if (i <= 13) return "R7";
    if (i <= 15) return "R5";
    if (i <= 19) return "R8";
    return "R6";
  endfunction

  task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {hlda_o, bus_oe_o, den_o, dtr_o, cyc_start_o, cyc_rfsh_o};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #25;
    check("R1", outs(), 6'b000000); // in reset
    @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      {hold_i, cyc_req_i, cyc_wr_i, rfsh_req_i, cyc_done_i} = VEC[i][10:6];
      step();
      check(vtag(i), outs(), VEC[i][5:0]);
    end

    // R1: reset while held, then no drive until first cycle
    hold_i = 1'b1;
    repeat (4) step();
    check("R2", outs(), 6'b100000);
    rst_ni = 1'b0;
    #1;
    check("R1", outs(), 6'b000000);
    @(negedge clk);
    hold_i = 1'b0;
    rst_ni = 1'b1;
    repeat (3) step();
    check("R1", outs(), 6'b000000);
    // R10: first write after reset turns the bus around
    cyc_req_i = 1'b1; cyc_wr_i = 1'b1;
    step();
    check("R10", outs(), 6'b010100);
    cyc_req_i = 1'b0;
    step();
    check("R9", outs(), 6'b011100);
    cyc_done_i = 1'b1;
    step();
    check("R9", outs(), 6'b010100);
    cyc_done_i = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule